// File: doc/BRIEF.md
# Horizontal Sync Source Mixer with Disable-Glitch Masking

This block chooses which of two active-low horizontal sync streams reaches the video output. The first stream comes from a free-running hardware line generator and the second from the software-driven video path. While the interrupt-based line generator is enabled, only the hardware stream passes. While it is disabled, only the software stream passes. The same enable also gates the reset request for the character row counter. Row resets that software activity causes during the blank parts of the frame therefore cannot move the first displayed character row away from zero.

The I/O write that turns the generator off can produce one stray software sync pulse. To keep that pulse out, the block stretches the enable for a fixed number of cycles after the enable input drops. Any I/O strobe seen inside that window starts the window again from its full length, so the whole write cycle stays on the hardware side. Both outputs are registered. Each output therefore reflects the inputs of the previous clock cycle, and no combinational glitch reaches it.

Top module: `sync_mixer`

## Requirements
- R1: During reset and in the first cycle after it, `sync_out_n` is 1 and `row_rst_out` is 0, and the stretch window is empty. After reset, the software path is selected at once if `gen_en` is 0.
- R2: If the effective enable is active in cycle N (for example, `gen_en` is 1), `sync_out_n` in cycle N+1 equals `hw_sync_n` from cycle N, whatever value `sw_sync_n` has.
- R3: If `gen_en` is 0 and the stretch window is empty in cycle N, `sync_out_n` in cycle N+1 equals `sw_sync_n` from cycle N.
- R4: `row_rst_out` in cycle N+1 equals `row_rst_req` from cycle N when the effective enable is inactive in cycle N, and is 0 otherwise.
- R5: After the last cycle with `gen_en` at 1, the hardware stream stays selected for exactly STRETCH_CYC further cycles (8 by default) while `io_strobe` is 0. The software stream is selected from the next cycle on.
- R6: An `io_strobe` of 1 in a cycle inside the stretch window reloads the window. The hardware stream then stays selected for STRETCH_CYC cycles after the last such strobe.
- R7: A low software sync pulse and a row reset request that arrive together with the disabling I/O strobe reach neither `sync_out_n` nor `row_rst_out`.
- R8: An `io_strobe` of 1 outside the stretch window, with `gen_en` at 0, does not select the hardware stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_sync_n | input | 1 | Hardware-generated sync, active low |
| sw_sync_n | input | 1 | Software-path sync, active low |
| row_rst_req | input | 1 | Raw character row counter reset request, active high |
| gen_en | input | 1 | Line generator enable level, active high |
| io_strobe | input | 1 | I/O write strobe, active high |
| sync_out_n | output | 1 | Registered mixed sync, active low |
| row_rst_out | output | 1 | Registered gated row counter reset, active high |

## Verification
The checker tests the following on every cycle. Hardware sync is forwarded and row reset is held off whenever `gen_en` is high. Software sync is forwarded whenever the effective enable is low. The enable is still active in the first cycle after `gen_en` falls. A row reset output always follows a request one cycle earlier. Some behaviour can only be seen in the bench scenarios: the exact window length, the reload of the window by a strobe part-way through it, the masking of a stray pulse that coincides with the disabling write, and a strobe outside the window having no effect.

// File: rtl/sync_mix_pkg.sv
package sync_mix_pkg;
    typedef struct packed {
        logic sync_n;
        logic row_rst;
    } mix_out_t;

    localparam mix_out_t MIX_IDLE = '{sync_n: 1'b1, row_rst: 1'b0};
endpackage

// File: rtl/en_stretcher.sv
module en_stretcher #(
    parameter int STRETCH_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    input  logic io_strobe,
    output logic eff_en
);
    localparam int CW = $clog2(STRETCH_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic win_open;

    assign win_open = (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (gen_en || (io_strobe && win_open)) begin
            st_d.cnt = LOAD;
        end else if (win_open) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_en = gen_en | win_open;
endmodule

// File: rtl/sync_select.sv
module sync_select
    import sync_mix_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     eff_en,
    input  logic     hw_sync_n,
    input  logic     sw_sync_n,
    input  logic     row_rst_req,
    output mix_out_t mix_q
);
    mix_out_t mix_d;

    always_comb begin
        mix_d = mix_q;
        if (eff_en) begin
            mix_d.sync_n  = hw_sync_n;
            mix_d.row_rst = 1'b0;
        end else begin
            mix_d.sync_n  = sw_sync_n;
            mix_d.row_rst = row_rst_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mix_q <= MIX_IDLE;
        end else begin
            mix_q <= mix_d;
        end
    end
endmodule

// File: rtl/sync_mixer.sv
module sync_mixer
    import sync_mix_pkg::*;
#(
    parameter int STRETCH_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_sync_n,
    input  logic sw_sync_n,
    input  logic row_rst_req,
    input  logic gen_en,
    input  logic io_strobe,
    output logic sync_out_n,
    output logic row_rst_out
);
    logic     eff_en;
    mix_out_t mix_q;

    en_stretcher #(.STRETCH_CYC(STRETCH_CYC)) stretch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_en    (gen_en),
        .io_strobe (io_strobe),
        .eff_en    (eff_en)
    );

    sync_select select_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .eff_en      (eff_en),
        .hw_sync_n   (hw_sync_n),
        .sw_sync_n   (sw_sync_n),
        .row_rst_req (row_rst_req),
        .mix_q       (mix_q)
    );

    assign sync_out_n  = mix_q.sync_n;
    assign row_rst_out = mix_q.row_rst;
endmodule

// File: rtl/sync_mixer_chk.sv
module sync_mixer_chk (
    input logic clk,
    input logic rst_n,
    input logic hw_sync_n,
    input logic sw_sync_n,
    input logic row_rst_req,
    input logic gen_en,
    input logic eff_en,
    input logic sync_out_n,
    input logic row_rst_out
);
    // R2
    hw_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en |=> (sync_out_n == $past(hw_sync_n)));

    // R3
    sw_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eff_en |=> (sync_out_n == $past(sw_sync_n)));

    // R4
    row_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en |=> !row_rst_out);

    // R4
    row_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_rst_out |-> $past(row_rst_req));

    // R5
    stretch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gen_en) && $past(rst_n)) |-> eff_en);
endmodule

bind sync_mixer sync_mixer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_sync_n   (hw_sync_n),
    .sw_sync_n   (sw_sync_n),
    .row_rst_req (row_rst_req),
    .gen_en      (gen_en),
    .eff_en      (eff_en),
    .sync_out_n  (sync_out_n),
    .row_rst_out (row_rst_out)
);

// File: tb/sync_mixer_tb_top.sv
module sync_mixer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STRETCH    = 8;
    localparam int NVEC       = 17;

    // Fields: {gen_en, io_strobe, hw_sync_n, sw_sync_n, row_rst_req, exp_sync, exp_rst}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1001100, // R2 hw low passes, R4 blocked
        7'b1010010, // R2 sw low ignored
        7'b1010110, // R4 request blocked
        7'b0110110, // R7 glitch with disabling write
        7'b0110110, // R7 strobe holds window
        7'b0011010, // R5 window 8
        7'b0000100, // R5 window 7, hw still selected
        7'b0010110, // R5 window 6
        7'b0010110, // R5 window 5
        7'b0010110, // R5 window 4
        7'b0010110, // R5 window 3
        7'b0010110, // R5 window 2
        7'b0010110, // R5 window 1
        7'b0010101, // R3 sw passes, R4 reset passes
        7'b0101010, // R8 strobe outside window
        7'b0010000, // R8 still software
        7'b0001010  // R3 sw high
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_sync_n = 1'b1, sw_sync_n = 1'b1, row_rst_req = 1'b0;
    logic gen_en = 1'b0, io_strobe = 1'b0;
    logic sync_out_n, row_rst_out;
    int   n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_mixer #(.STRETCH_CYC(STRETCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_sync_n(hw_sync_n), .sw_sync_n(sw_sync_n),
        .row_rst_req(row_rst_req), .gen_en(gen_en), .io_strobe(io_strobe),
        .sync_out_n(sync_out_n), .row_rst_out(row_rst_out)
    );

    function automatic string vec_tag(int i);
        if (i < 3)       return "R2";
        else if (i < 5)  return "R7";
        else if (i < 13) return "R5";
        else if (i == 13) return "R3";
        else if (i < 16) return "R8";
        else             return "R3";
    endfunction

    task automatic check(string req, logic exp_s, logic exp_r);
        n_tests++;
        if (sync_out_n !== exp_s || row_rst_out !== exp_r) begin
            n_fail++;
            $display("FAIL %s: sync_out_n=%b row_rst_out=%b expected %b %b",
                     req, sync_out_n, row_rst_out, exp_s, exp_r);
        end
    endtask

    task automatic step(logic g, logic i, logic h, logic s, logic r);
        @(negedge clk);
        gen_en = g; io_strobe = i; hw_sync_n = h; sw_sync_n = s; row_rst_req = r;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k][6], VEC[k][5], VEC[k][4], VEC[k][3], VEC[k][2]);
            check(vec_tag(k), VEC[k][1], VEC[k][0]);
        end

        // R6: strobe part-way through the window reloads it
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            check("R6", 1'b0, 1'b0);
        end
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R6", 1'b0, 1'b0);
        for (int k = 0; k < STRETCH; k++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
            check("R6", 1'b0, 1'b0);
        end
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R6", 1'b1, 1'b1);

        // R7: glitch on sync and row reset during the disabling write, then expiry
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R7", 1'b1, 1'b0);

        // R1: mid-run reset clears outputs and window
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", 1'b1, 1'b0);
        gen_en = 1'b0; io_strobe = 1'b0; hw_sync_n = 1'b0; sw_sync_n = 1'b1; row_rst_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        sw_sync_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule